// File: doc/BRIEF.md
# Two-Share Domain-Oriented Masked AND

This block computes the bitwise AND of two secrets, each held as two Boolean shares, without ever recombining the shares of a secret. Shares belonging to domain A (`x_a`, `y_a`) and domain B (`x_b`, `y_b`) are multiplied pairwise. The two products that mix domains are each remasked with the same fresh random bit per data bit. All four partial terms are then held in a register before they are folded back into one output share per domain. The register stops glitches in the folding logic from combining terms that have not yet been remasked.

A caller presents a fresh sharing of both operands and one random vector per cycle, marked by `in_valid`. The two result shares appear together with `out_valid` after the pipeline latency, which is two cycles in the default configuration. A new operation may start on every cycle. The sharings of `x` and `y` must be independent of each other, and `rnd` must be fresh and uniform for each operation. The caller is responsible for both the initial sharing and the random source.

Top module: `masked_and_dom`

## Requirements
- R1: In the cycle after a clock edge at which `rst` is high, `out_valid` is 0 and both result shares `z_a` and `z_b` are all zeros.
- R2: When `out_valid` is 1, `z_a ^ z_b` equals `(x_a ^ x_b) & (y_a ^ y_b)` of the operands accepted two cycles earlier, for every bit.
- R3: `out_valid` is `in_valid` delayed by exactly two clock cycles. Operations presented on consecutive cycles each produce their own result on consecutive cycles.
- R4: Domain A's result share is exactly `(x_a & y_a) ^ (x_a & y_b) ^ rnd`. Domain B's result share is exactly `(x_b & y_a) ^ rnd ^ (x_b & y_b)`. Both use the operands and `rnd` of the same accepted operation.
- R5: Each bit of `rnd` is added to both cross-domain terms. Two operations with equal operand shares but different `rnd` therefore give results whose `z_a` shares differ by exactly `rnd1 ^ rnd2`, whose `z_b` shares also differ by `rnd1 ^ rnd2`, and whose unmasked result is the same.
- R6: A synchronous reset asserted while operations are in flight discards them. No `out_valid` pulse appears for an operation whose two-cycle window included a reset edge.
- R7: While no new result is emitted (`out_valid` is 0), `z_a` and `z_b` keep their last value.
- R8: Each result bit depends only on the same bit position of the four operand shares and of `rnd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand shares and `rnd` are valid this cycle |
| x_a | input | WIDTH | First operand, domain A share |
| x_b | input | WIDTH | First operand, domain B share |
| y_a | input | WIDTH | Second operand, domain A share |
| y_b | input | WIDTH | Second operand, domain B share |
| rnd | input | WIDTH | Fresh random bits, one per data bit |
| out_valid | output | 1 | Result shares are valid this cycle |
| z_a | output | WIDTH | Result, domain A share |
| z_b | output | WIDTH | Result, domain B share |

## Verification
The hardest condition to reach from the ports is a reset edge that lands on an operation that has passed the term register but not the output stage. Only a pipeline that is really cleared keeps that operation from surfacing one cycle later. The bench creates this case by presenting a valid operation, asserting `rst` exactly one cycle later, and then watching `out_valid` and both shares over the following cycles. The bench also streams table vectors and random operations back to back, and it reuses one operand sharing with two different random vectors. This exposes a wrong pairing of terms across pipeline stages, and it exposes a random bit added to only one cross term.

// File: rtl/dom_and_pkg.sv
package dom_and_pkg;
   // Choice of how the compressed shares leave the block
   typedef enum logic {
      ZOUT_COMB = 1'b0,   // fold combinationally after the term register
      ZOUT_FLOP = 1'b1    // fold into an output register (one more cycle)
   } zout_mode_e;

   // Result latency for a given output mode
   function automatic int unsigned zout_latency(zout_mode_e m);
      return (m == ZOUT_FLOP) ? 2 : 1;
   endfunction
endpackage

// File: rtl/dom_cross_terms.sv
module dom_cross_terms #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] x_a,
   input  logic [WIDTH-1:0] x_b,
   input  logic [WIDTH-1:0] y_a,
   input  logic [WIDTH-1:0] y_b,
   input  logic [WIDTH-1:0] rnd,
   output logic [WIDTH-1:0] t_aa,
   output logic [WIDTH-1:0] t_ab,
   output logic [WIDTH-1:0] t_ba,
   output logic [WIDTH-1:0] t_bb
);
   initial begin
      width_ok_chk : assert (WIDTH >= 1)
         else $error("dom_cross_terms: WIDTH must be at least 1");
   end

   // One slice per bit: inner-domain products stay bare,
   // cross-domain products share the same fresh bit.
   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      always_comb begin
         t_aa[g] = x_a[g] & y_a[g];
         t_ab[g] = (x_a[g] & y_b[g]) ^ rnd[g];
         t_ba[g] = (x_b[g] & y_a[g]) ^ rnd[g];
         t_bb[g] = x_b[g] & y_b[g];
      end
   end
endmodule

// File: rtl/dom_term_reg.sv
module dom_term_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] d_aa,
   input  logic [WIDTH-1:0] d_ab,
   input  logic [WIDTH-1:0] d_ba,
   input  logic [WIDTH-1:0] d_bb,
   output logic             q_vld,
   output logic [WIDTH-1:0] q_aa,
   output logic [WIDTH-1:0] q_ab,
   output logic [WIDTH-1:0] q_ba,
   output logic [WIDTH-1:0] q_bb
);
   initial begin
      width_ok_chk : assert (WIDTH >= 1)
         else $error("dom_term_reg: WIDTH must be at least 1");
   end

   // All four terms are captured together; nothing folds before this edge.
   always_ff @(posedge clk) begin
      if (rst) begin
         q_vld <= 1'b0;
         q_aa  <= '0;
         q_ab  <= '0;
         q_ba  <= '0;
         q_bb  <= '0;
      end else begin
         q_vld <= load;
         if (load) begin
            q_aa <= d_aa;
            q_ab <= d_ab;
            q_ba <= d_ba;
            q_bb <= d_bb;
         end
      end
   end

   // R6
   term_clear_chk : assert property (@(posedge clk)
      rst |=> (!q_vld && q_aa == '0 && q_ab == '0 && q_ba == '0 && q_bb == '0));

   // R3
   term_accept_chk : assert property (@(posedge clk) disable iff (rst)
      load |=> q_vld);
endmodule

// File: rtl/dom_compress.sv
module dom_compress
   import dom_and_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter zout_mode_e  ZOUT  = ZOUT_FLOP
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             t_vld,
   input  logic [WIDTH-1:0] t_aa,
   input  logic [WIDTH-1:0] t_ab,
   input  logic [WIDTH-1:0] t_ba,
   input  logic [WIDTH-1:0] t_bb,
   output logic             z_vld,
   output logic [WIDTH-1:0] z_a,
   output logic [WIDTH-1:0] z_b
);
   logic [WIDTH-1:0] fold_a;
   logic [WIDTH-1:0] fold_b;

   initial begin
      width_ok_chk : assert (WIDTH >= 1)
         else $error("dom_compress: WIDTH must be at least 1");
   end

   // Each domain folds only its own two terms.
   always_comb begin
      fold_a = t_aa ^ t_ab;
      fold_b = t_ba ^ t_bb;
   end

   if (ZOUT == ZOUT_FLOP) begin : g_flop
      always_ff @(posedge clk) begin
         if (rst) begin
            z_vld <= 1'b0;
            z_a   <= '0;
            z_b   <= '0;
         end else begin
            z_vld <= t_vld;
            if (t_vld) begin
               z_a <= fold_a;
               z_b <= fold_b;
            end
         end
      end

      // R7
      zout_hold_chk : assert property (@(posedge clk) disable iff (rst)
         !t_vld |=> ($stable(z_a) && $stable(z_b)));

      // R3
      zout_follow_chk : assert property (@(posedge clk) disable iff (rst)
         t_vld |=> z_vld);
   end else begin : g_comb
      always_comb begin
         z_vld = t_vld;
         z_a   = fold_a;
         z_b   = fold_b;
      end
   end
endmodule

// File: rtl/masked_and_dom.sv
module masked_and_dom
   import dom_and_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter zout_mode_e  ZOUT  = ZOUT_FLOP
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] x_a,
   input  logic [WIDTH-1:0] x_b,
   input  logic [WIDTH-1:0] y_a,
   input  logic [WIDTH-1:0] y_b,
   input  logic [WIDTH-1:0] rnd,
   output logic             out_valid,
   output logic [WIDTH-1:0] z_a,
   output logic [WIDTH-1:0] z_b
);
   localparam int unsigned LAT = zout_latency(ZOUT);

   logic [WIDTH-1:0] c_aa, c_ab, c_ba, c_bb;
   logic [WIDTH-1:0] r_aa, r_ab, r_ba, r_bb;
   logic             r_vld;

   initial begin
      width_ok_chk : assert (WIDTH >= 1)
         else $error("masked_and_dom: WIDTH must be at least 1");
      lat_ok_chk : assert (LAT == 1 || LAT == 2)
         else $error("masked_and_dom: unexpected latency");
   end

   dom_cross_terms #(.WIDTH(WIDTH)) i_terms (
      .x_a (x_a),  .x_b (x_b),
      .y_a (y_a),  .y_b (y_b),
      .rnd (rnd),
      .t_aa(c_aa), .t_ab(c_ab), .t_ba(c_ba), .t_bb(c_bb)
   );

   dom_term_reg #(.WIDTH(WIDTH)) i_treg (
      .clk  (clk),  .rst (rst),  .load(in_valid),
      .d_aa (c_aa), .d_ab(c_ab), .d_ba(c_ba), .d_bb(c_bb),
      .q_vld(r_vld),
      .q_aa (r_aa), .q_ab(r_ab), .q_ba(r_ba), .q_bb(r_bb)
   );

   dom_compress #(.WIDTH(WIDTH), .ZOUT(ZOUT)) i_fold (
      .clk  (clk),  .rst (rst),  .t_vld(r_vld),
      .t_aa (r_aa), .t_ab(r_ab), .t_ba(r_ba), .t_bb(r_bb),
      .z_vld(out_valid), .z_a(z_a), .z_b(z_b)
   );

   // R1
   reset_state_chk : assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && z_a == '0 && z_b == '0));

   // R2
   unmask_chk : assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ((z_a ^ z_b) ==
         (($past(x_a, LAT) ^ $past(x_b, LAT)) & ($past(y_a, LAT) ^ $past(y_b, LAT)))));

   // R4
   share_a_chk : assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (z_a == (($past(x_a, LAT) & $past(y_a, LAT)) ^
                             ($past(x_a, LAT) & $past(y_b, LAT)) ^ $past(rnd, LAT))));

   // R3
   no_spurious_chk : assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !r_vld);
endmodule

// File: tb/test_masked_and_dom.sv
module test_masked_and_dom;
   localparam int W  = 8;
   localparam int NV = 8;
   localparam int NR = 200;

   // {x_a, x_b, y_a, y_b, rnd}
   localparam logic [5*W-1:0] VEC [NV] = '{
      40'h00_00_00_00_00,
      40'hFF_00_FF_00_00,
      40'hFF_FF_FF_FF_FF,
      40'hA5_5A_3C_C3_0F,
      40'hA5_5A_3C_C3_F0,
      40'h12_34_56_78_9A,
      40'h80_00_00_01_01,
      40'h01_00_80_80_FF
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [W-1:0] x_a = '0, x_b = '0, y_a = '0, y_b = '0, rnd = '0;
   logic         out_valid;
   logic [W-1:0] z_a, z_b;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   logic [W-1:0] ea [NR];
   logic [W-1:0] eb [NR];
   logic [W-1:0] keep_a, keep_b;

   always #2 clk = ~clk;

   masked_and_dom #(.WIDTH(W)) i_masked_and_dom (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .x_a(x_a), .x_b(x_b), .y_a(y_a), .y_b(y_b), .rnd(rnd),
      .out_valid(out_valid), .z_a(z_a), .z_b(z_b)
   );

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++; fails++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
         finish_run();
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] share_a(logic [5*W-1:0] v);
      logic [W-1:0] xa, xb, ya, yb, r;
      {xa, xb, ya, yb, r} = v;
      return (xa & ya) ^ (xa & yb) ^ r;
   endfunction

   function automatic logic [W-1:0] share_b(logic [5*W-1:0] v);
      logic [W-1:0] xa, xb, ya, yb, r;
      {xa, xb, ya, yb, r} = v;
      return (xb & ya) ^ r ^ (xb & yb);
   endfunction

   function automatic logic [W-1:0] plain(logic [5*W-1:0] v);
      logic [W-1:0] xa, xb, ya, yb, r;
      {xa, xb, ya, yb, r} = v;
      return (xa ^ xb) & (ya ^ yb);
   endfunction

   task automatic drive(logic v, logic [5*W-1:0] d);
      in_valid = v;
      {x_a, x_b, y_a, y_b, rnd} = d;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: state after reset
      chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
      chk("R1 z_a", {24'd0, z_a}, 32'd0);
      chk("R1 z_b", {24'd0, z_b}, 32'd0);
      rst = 1'b0;

      // Table walk, back to back; result of entry i read two negedges later
      for (int i = 0; i < NV + 2; i++) begin
         if (i >= 2) begin
            chk("R3 out_valid stream", {31'd0, out_valid}, 32'd1);
            chk("R2 unmasked", {24'd0, z_a ^ z_b}, {24'd0, plain(VEC[i-2])});
            chk("R4 share a", {24'd0, z_a}, {24'd0, share_a(VEC[i-2])});
            chk("R4 share b", {24'd0, z_b}, {24'd0, share_b(VEC[i-2])});
            if (i - 2 == 3) begin keep_a = z_a; keep_b = z_b; end
            if (i - 2 == 4) begin
               // R5: same sharing, rnd 0F vs F0
               chk("R5 a diff", {24'd0, z_a ^ keep_a}, 32'h0000_00FF);
               chk("R5 b diff", {24'd0, z_b ^ keep_b}, 32'h0000_00FF);
               chk("R5 same value", {24'd0, z_a ^ z_b}, {24'd0, keep_a ^ keep_b});
            end
         end
         if (i < NV) drive(1'b1, VEC[i]);
         else        drive(1'b0, '0);
         @(negedge clk);
      end

      // R7: idle with changing inputs, outputs hold entry 7
      keep_a = z_a; keep_b = z_b;
      for (int k = 0; k < 4; k++) begin
         drive(1'b0, {5{8'h5C + 8'(k)}});
         @(negedge clk);
         chk("R7 out_valid idle", {31'd0, out_valid}, 32'd0);
         chk("R7 z_a hold", {24'd0, z_a}, {24'd0, keep_a});
         chk("R7 z_b hold", {24'd0, z_b}, {24'd0, keep_b});
      end

      // R8: single bit set in one position only affects that bit
      drive(1'b1, {8'h10, 8'h00, 8'h10, 8'h00, 8'h00});
      @(negedge clk);
      drive(1'b0, '0);
      @(negedge clk);
      chk("R8 bit isolation", {24'd0, z_a ^ z_b}, 32'h0000_0010);

      // R6: reset while an operation sits in the term register
      drive(1'b1, 40'hFF_00_FF_00_00);
      @(negedge clk);
      drive(1'b0, '0);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R6 flushed valid", {31'd0, out_valid}, 32'd0);
      chk("R1 z_a after reset", {24'd0, z_a}, 32'd0);
      @(negedge clk);
      chk("R6 no late valid", {31'd0, out_valid}, 32'd0);

      // R2/R3: random stream, back to back
      for (int i = 0; i < NR + 2; i++) begin
         if (i >= 2) begin
            chk("R3 random valid", {31'd0, out_valid}, 32'd1);
            chk("R4 random a", {24'd0, z_a}, {24'd0, ea[i-2]});
            chk("R4 random b", {24'd0, z_b}, {24'd0, eb[i-2]});
         end
         if (i < NR) begin
            logic [5*W-1:0] v;
            v = {$urandom(), 8'($urandom())};
            ea[i] = share_a(v);
            eb[i] = share_b(v);
            drive(1'b1, v);
         end else drive(1'b0, '0);
         @(negedge clk);
      end
      chk("R3 stream ends", {31'd0, out_valid}, 32'd0);

      finish_run();
   end
endmodule